// File: doc/BRIEF.md
# Sequential Read Prefetch Buffer

This block sits between a host read port and a word-addressed memory port. When a read arrives and the buffer cannot serve it, the block fetches a run of eight consecutive memory words into a small local store. The run starts at the word the host asked for. That read, and any later read that falls inside the run, is answered from the local store. A later read is served this way even if its word is still on its way from memory.

A read outside the current run throws away everything buffered. It then starts a fresh run at the new address. A mode input selects between prefetching and a pass-through mode. In pass-through mode every host read becomes exactly one memory read, and the buffer is left empty. A host write pulse, or any change of the mode input, empties the buffer so that stale words are never returned.

The host side is a valid/ready handshake. The host holds `rd_valid` and `rd_addr` until it sees a one-cycle `rd_ready` pulse, with the word on `rd_data`. The memory side is a request/acknowledge handshake that moves one word per acknowledge.

Top module: `seqrd_prefetch`

## Requirements
- R1: With `pf_enable` = 1, a read that misses starts a run that requests exactly `DEPTH` (8) words from memory, at addresses A, A+1, ..., A+7, in that order, where A is the requested address.
- R2: A read whose word lies in the current run and has already arrived is answered with that word and causes no memory request.
- R3: A read outside the current run discards the whole run, even if a fill is still in progress. A new run then starts at the new address, and the host receives the word stored at that address.
- R4: A read to a word of the current run that has not arrived yet waits for that word. It does not restart or lengthen the run, so the run still makes exactly 8 memory requests.
- R5: With `pf_enable` = 0, each host read makes exactly one memory request, at the requested address, and returns that memory word.
- R6: A one-cycle `host_wr` pulse invalidates every buffered word. A later read of a word that was buffered is fetched from memory again and returns the current memory contents.
- R7: Any change of `pf_enable` invalidates every buffered word. After prefetching is re-enabled, a read of a formerly buffered address starts a new 8-word run.
- R8: For each request, `rd_ready` is high for exactly one cycle. It is high only while `rd_valid` was held and the returned word is valid. It is low in the cycle after the pulse.
- R9: While `rst` is high, and in the cycle after it is released, `rd_ready` and `mem_req` are 0. The first read after reset misses.
- R10: Once `mem_req` is raised, it stays high with a stable `mem_addr` until the cycle in which `mem_ack` is sampled high.
- R11: Run addresses wrap modulo 2^AW. A run started at 0xFFFD (AW = 16) fetches 0xFFFD..0x0004, and a read of 0x0002 is then a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pf_enable | input | 1 | 1 = prefetch through the buffer, 0 = pass-through |
| host_wr | input | 1 | Pulse marking a host write; invalidates the buffer |
| rd_valid | input | 1 | Host read request, held until `rd_ready` |
| rd_addr | input | AW | Word address of the host read |
| rd_ready | output | 1 | One-cycle pulse: `rd_data` holds the answer |
| rd_data | output | DW | Returned read word |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory word address, stable while `mem_req` waits |
| mem_ack | input | 1 | Memory acknowledge; `mem_rdata` is valid |
| mem_rdata | input | DW | Memory read word |

## Verification
The bench targets a miss that lands while an older run is still filling (R3). A design that failed to stop the old fill would let late words from that run be marked valid, so the host would get data from the wrong address. It also reads a word of a slow run before that word arrives (R4). A design that treated this as a miss would restart the run, and the bench would count more than eight memory acknowledges for it.

Memory contents change with every write epoch. A design that skipped the flush on `host_wr` or on a mode change would therefore return an old-epoch word or fetch too few words (R6, R7). A run placed across the top of the address space catches a hit compare or an address counter that does not wrap (R11).

// File: rtl/seqrd_pkg.sv
package seqrd_pkg;

  // Outcome of comparing a host address against the current run
  typedef enum logic [1:0] {
    LOOK_IDLE = 2'd0,
    LOOK_HIT  = 2'd1,
    LOOK_WAIT = 2'd2,
    LOOK_MISS = 2'd3
  } look_e;

endpackage

// File: rtl/seqrd_store.sv
// Word store for one run: one write port, one registered read port.
module seqrd_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] ram_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram_q[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= ram_q[ridx];
  end

endmodule

// File: rtl/seqrd_tag.sv
// Run base address, per-word valid bits and the hit/wait/miss compare.
module seqrd_tag
  import seqrd_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             start,
  input  logic [AW-1:0]    start_addr,
  input  logic             fill_we,
  input  logic [IW-1:0]    fill_idx,
  input  logic             fill_busy,
  input  logic [AW-1:0]    look_addr,
  output look_e            look,
  output logic [IW-1:0]    look_idx,
  output logic [DEPTH-1:0] valid_o
);

  localparam logic [AW-1:0] SPAN = AW'(DEPTH);

  logic [AW-1:0]    base_q;
  logic             live_q;
  logic [DEPTH-1:0] valid_q;
  logic [DEPTH-1:0] set_v;
  logic [AW-1:0]    off;
  logic             in_run;

  // One set strobe per word lane
  for (genvar i = 0; i < DEPTH; i++) begin : g_lane
    assign set_v[i] = fill_we && live_q && (fill_idx == IW'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      live_q  <= 1'b0;
      valid_q <= '0;
    end else if (flush) begin
      live_q  <= 1'b0;
      valid_q <= '0;
    end else if (start) begin
      base_q  <= start_addr;
      live_q  <= 1'b1;
      valid_q <= '0;
    end else begin
      valid_q <= valid_q | set_v;
    end
  end

  // Modular distance from the run base; wraps with the address space
  assign off      = look_addr - base_q;
  assign in_run   = live_q && (off < SPAN);
  assign look_idx = off[IW-1:0];
  assign valid_o  = valid_q;

  always_comb begin
    if (in_run && valid_q[look_idx])  look = LOOK_HIT;
    else if (in_run && fill_busy)     look = LOOK_WAIT;
    else                              look = LOOK_MISS;
  end

  p_flush_clears_r6: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_q == '0));

endmodule

// File: rtl/seqrd_fill.sv
// Fill sequencer: walks consecutive addresses with a req/ack handshake.
module seqrd_fill #(
  parameter int AW    = 16,
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          single,
  input  logic          stop,
  input  logic          mem_ack,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          busy,
  output logic          word_we,
  output logic [IW-1:0] word_idx
);

  logic          busy_q;
  logic          halt_q;
  logic [AW-1:0] addr_q;
  logic [IW-1:0] cnt_q;
  logic [IW-1:0] last_q;
  logic          end_now;

  assign end_now = (cnt_q == last_q) || halt_q || stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      halt_q <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
      last_q <= '0;
    end else if (!busy_q) begin
      halt_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        addr_q <= start_addr;
        cnt_q  <= '0;
        last_q <= single ? '0 : IW'(DEPTH - 1);
      end
    end else begin
      if (stop) halt_q <= 1'b1;
      if (mem_ack) begin
        if (end_now) begin
          busy_q <= 1'b0;
        end else begin
          addr_q <= addr_q + AW'(1);
          cnt_q  <= cnt_q + IW'(1);
        end
      end
    end
  end

  assign mem_req  = busy_q;
  assign mem_addr = addr_q;
  assign busy     = busy_q;
  assign word_we  = busy_q && mem_ack;
  assign word_idx = cnt_q;

  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_addr_step_r1: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && (cnt_q != last_q) && !halt_q && !stop)
      |=> (mem_req && (mem_addr == $past(mem_addr) + AW'(1))));

endmodule

// File: rtl/seqrd_prefetch.sv
// Top: host handshake, mode handling, bypass path and run control.
module seqrd_prefetch
  import seqrd_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pf_enable,
  input  logic          host_wr,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);

  localparam int IW = $clog2(DEPTH);

  look_e            look;
  logic [IW-1:0]    look_idx;
  logic [DEPTH-1:0] valid_w;
  logic             fill_busy;
  logic             word_we;
  logic [IW-1:0]    word_idx;
  logic [DW-1:0]    store_q;

  logic          pf_q;
  logic          rdy_q;
  logic          src_byp_q;
  logic          byp_busy_q;
  logic [DW-1:0] byp_data_q;

  logic mode_chg, flush_ext, ask;
  logic hit_go, miss, start_run, byp_go, byp_done;
  logic tag_flush, fill_stop, run_we;

  assign mode_chg  = pf_enable != pf_q;
  assign flush_ext = host_wr || mode_chg;
  assign ask       = rd_valid && !rdy_q && !byp_busy_q;

  assign hit_go    = ask && pf_enable && !flush_ext && (look == LOOK_HIT);
  assign miss      = ask && pf_enable && !flush_ext && (look == LOOK_MISS);
  assign start_run = miss && !fill_busy;
  assign byp_go    = ask && !pf_enable && !flush_ext && !fill_busy;
  assign byp_done  = byp_busy_q && word_we;

  assign tag_flush = flush_ext || (miss && fill_busy);
  assign fill_stop = fill_busy && (flush_ext || miss) && !byp_busy_q;
  assign run_we    = word_we && !byp_busy_q;

  seqrd_tag #(.AW(AW), .DEPTH(DEPTH)) u_tag (
    .clk        (clk),
    .rst        (rst),
    .flush      (tag_flush),
    .start      (start_run),
    .start_addr (rd_addr),
    .fill_we    (run_we),
    .fill_idx   (word_idx),
    .fill_busy  (fill_busy),
    .look_addr  (rd_addr),
    .look       (look),
    .look_idx   (look_idx),
    .valid_o    (valid_w)
  );

  seqrd_fill #(.AW(AW), .DEPTH(DEPTH)) u_fill (
    .clk        (clk),
    .rst        (rst),
    .start      (start_run || byp_go),
    .start_addr (rd_addr),
    .single     (byp_go),
    .stop       (fill_stop),
    .mem_ack    (mem_ack),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .busy       (fill_busy),
    .word_we    (word_we),
    .word_idx   (word_idx)
  );

  seqrd_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (run_we),
    .widx  (word_idx),
    .wdata (mem_rdata),
    .re    (hit_go),
    .ridx  (look_idx),
    .rdata (store_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_q       <= pf_enable;
      rdy_q      <= 1'b0;
      src_byp_q  <= 1'b0;
      byp_busy_q <= 1'b0;
      byp_data_q <= '0;
    end else begin
      pf_q  <= pf_enable;
      rdy_q <= hit_go || byp_done;
      if (hit_go)        src_byp_q <= 1'b0;
      else if (byp_done) src_byp_q <= 1'b1;
      if (byp_done)      byp_data_q <= mem_rdata;
      if (byp_go)        byp_busy_q <= 1'b1;
      else if (byp_done) byp_busy_q <= 1'b0;
    end
  end

  assign rd_ready = rdy_q;
  assign rd_data  = src_byp_q ? byp_data_q : store_q;

  p_ready_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rd_ready |=> !rd_ready);

  p_ready_after_valid_r8: assert property (@(posedge clk) disable iff (rst)
    rd_ready |-> $past(rd_valid));

  p_hit_no_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    (hit_go && !fill_busy) |=> !mem_req);

  p_bypass_empty_r5: assert property (@(posedge clk) disable iff (rst)
    !pf_enable |=> (valid_w == '0));

  p_mode_flush_r7: assert property (@(posedge clk) disable iff (rst)
    (pf_enable != $past(pf_enable)) |=> (valid_w == '0));

endmodule

// File: tb/seqrd_prefetch_bench.sv
module seqrd_prefetch_bench;

  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          pf_enable;
  logic          host_wr;
  logic          rd_valid;
  logic [AW-1:0] rd_addr;
  logic          rd_ready;
  logic [DW-1:0] rd_data;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_ack;
  logic [DW-1:0] mem_rdata;

  int checks = 0;
  int errors = 0;
  int acks   = 0;
  int epoch  = 0;
  int slow   = 0;
  int dly    = 0;
  int hold_viol = 0;
  logic          pend = 1'b0;
  logic [AW-1:0] pend_addr = '0;
  logic [AW-1:0] alog [$];

  always #2 clk = ~clk;

  seqrd_prefetch #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_seqrd_prefetch (
    .clk       (clk),
    .rst       (rst),
    .pf_enable (pf_enable),
    .host_wr   (host_wr),
    .rd_valid  (rd_valid),
    .rd_addr   (rd_addr),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata)
  );

  function automatic logic [DW-1:0] model(input logic [AW-1:0] a, input int ep);
    logic [DW-1:0] v;
    v = {16'h0, a} * 32'h9E37_79B1;
    v = v ^ (ep << 20) ^ 32'h5A5A_0000;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory responder: ack after a delay, log every fetched address
  initial begin
    mem_ack   = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        pend    = 1'b0;
      end else if (mem_req && !rst) begin
        if (pend && mem_addr != pend_addr) hold_viol++;
        pend      = 1'b1;
        pend_addr = mem_addr;
        if (dly == 0) begin
          mem_ack   = 1'b1;
          mem_rdata = model(mem_addr, epoch);
          alog.push_back(mem_addr);
          acks++;
          dly = (slow != 0) ? 4 : int'($urandom_range(2, 0));
        end else begin
          dly--;
        end
      end else if (pend) begin
        hold_viol++;
        pend = 1'b0;
      end
    end
  end

  task automatic host_read(input logic [AW-1:0] a, input string req);
    int n;
    logic [DW-1:0] exp;
    @(negedge clk);
    rd_valid = 1'b1;
    rd_addr  = a;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!rd_ready && n < 400);
    exp = model(a, epoch);
    chk(rd_ready === 1'b1 && rd_data === exp, req, rd_data, exp);
    rd_valid = 1'b0;
    @(negedge clk);
    chk(rd_ready === 1'b0, "R8 ready pulse", {31'b0, rd_ready}, 32'h0);
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while ((mem_req || mem_ack) && n < 400);
    if (n >= 400) chk(1'b0, "watchdog idle", 32'(n), 32'h0);
  endtask

  task automatic pulse_wr();
    @(negedge clk);
    host_wr = 1'b1;
    epoch++;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic check_run(input logic [AW-1:0] a, input int l0, input string req);
    bit ok;
    ok = (alog.size() >= l0 + DEPTH);
    for (int i = 0; i < DEPTH && ok; i++)
      if (alog[l0 + i] != a + AW'(i)) ok = 1'b0;
    chk(ok, req, ok ? 32'h1 : 32'h0, 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int a0;
    int l0;
    logic [AW-1:0] ra;
    void'($urandom(32'd4242));
    rst       = 1'b1;
    pf_enable = 1'b1;
    host_wr   = 1'b0;
    rd_valid  = 1'b0;
    rd_addr   = '0;
    repeat (4) @(negedge clk);
    // R9: quiet outputs during reset
    chk(rd_ready === 1'b0 && mem_req === 1'b0, "R9 reset", {30'b0, rd_ready, mem_req}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(rd_ready === 1'b0 && mem_req === 1'b0, "R9 after release", {30'b0, rd_ready, mem_req}, 32'h0);

    // R1: first read misses and fetches an 8-word run
    a0 = acks; l0 = alog.size();
    host_read(16'h0100, "R1 data");
    wait_idle();
    chk(acks - a0 == DEPTH, "R1 run length", 32'(acks - a0), 32'(DEPTH));
    check_run(16'h0100, l0, "R1 run order");

    // R2: hits return buffered words with no memory access
    a0 = acks;
    host_read(16'h0103, "R2 hit");
    host_read(16'h0107, "R2 hit last");
    host_read(16'h0100, "R2 hit first");
    chk(acks == a0, "R2 no fetch", 32'(acks - a0), 32'h0);

    // R3: just past the run
    a0 = acks; l0 = alog.size();
    host_read(16'h0108, "R3 data");
    wait_idle();
    check_run(16'h0108, l0, "R3 refetch");

    // R3: miss while a slow fill is still running
    slow = 1;
    host_read(16'h0200, "R3 first");
    l0 = alog.size();
    host_read(16'h0300, "R3 mid-fill miss");
    wait_idle();
    chk(alog.size() >= DEPTH && alog[alog.size() - DEPTH] == 16'h0300,
        "R3 new base", 32'(alog[alog.size() - DEPTH]), 32'h0300);
    host_read(16'h0305, "R3 new run hit");

    // R4: read of a word still in flight waits, no restart
    a0 = acks;
    host_read(16'h0400, "R4 first");
    host_read(16'h0406, "R4 pending word");
    wait_idle();
    chk(acks - a0 == DEPTH, "R4 single run", 32'(acks - a0), 32'(DEPTH));
    slow = 0;

    // R6: host write invalidates buffered data
    pulse_wr();
    a0 = acks;
    host_read(16'h0403, "R6 fresh data");
    wait_idle();
    chk(acks > a0, "R6 refetch", 32'(acks - a0), 32'(DEPTH));

    // R5: pass-through mode
    host_read(16'h0600, "R7 setup");
    wait_idle();
    @(negedge clk);
    pf_enable = 1'b0;
    for (int k = 0; k < 2; k++) begin
      a0 = acks;
      host_read(16'h0500, "R5 bypass data");
      wait_idle();
      chk(acks - a0 == 1, "R5 one access", 32'(acks - a0), 32'h1);
      chk(alog[alog.size() - 1] == 16'h0500, "R5 address", 32'(alog[alog.size() - 1]), 32'h0500);
    end

    // R7: re-enable; old run must be gone
    @(negedge clk);
    pf_enable = 1'b1;
    a0 = acks; l0 = alog.size();
    host_read(16'h0603, "R7 data");
    wait_idle();
    chk(acks - a0 == DEPTH, "R7 new run", 32'(acks - a0), 32'(DEPTH));
    check_run(16'h0603, l0, "R7 run base");

    // R11: run across the top of the address space
    l0 = alog.size();
    host_read(16'hFFFD, "R11 data");
    wait_idle();
    check_run(16'hFFFD, l0, "R11 wrap order");
    a0 = acks;
    host_read(16'h0002, "R11 wrapped hit");
    chk(acks == a0, "R11 no fetch", 32'(acks - a0), 32'h0);

    // Random mix
    for (int it = 0; it < 300; it++) begin
      if ($urandom_range(19, 0) == 0) begin
        @(negedge clk);
        pf_enable = ~pf_enable;
      end
      if ($urandom_range(14, 0) == 0) pulse_wr();
      ra = 16'h0700 + AW'($urandom_range(23, 0));
      host_read(ra, pf_enable ? "R3 random prefetch" : "R5 random bypass");
    end
    wait_idle();

    chk(hold_viol == 0, "R10 request hold", 32'(hold_viol), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule